// File: doc/BRIEF.md
# NOR Flash Burst Read Sequencer

This block issues multi-beat reads to a parallel asynchronous NOR flash device that sits behind an external address latch. A client asks for a burst with a single-cycle request that carries a base word address and a beat count. The block then drives the latch enable, the active-low chip select and output enable, and the address bus, and it captures the flash data bus once per beat. Each captured word comes out with a one-cycle strobe.

Six timing fields, each a count of internal clock cycles, set the length of every phase. The fields are latch setup, latch hold, address-to-select delay, select-to-output-enable delay, first-access time and sequential-access time. They are captured when a request is accepted. The first address stays on the bus for the sum of the first five fields plus three cycles. Each later address stays on the bus for the sequential-access field plus five cycles, and the word address increments by one for each beat.

The controller has seven states. IDLE moves to LATCH when a request is accepted. LATCH moves to LHOLD. LHOLD moves to CSDLY, or to OEDLY, or straight to FIRST, depending on which of the delay fields are zero. CSDLY moves to OEDLY or to FIRST. OEDLY moves to FIRST. FIRST moves to SEQ, or back to IDLE when it held the last beat. SEQ moves to SEQ again, or back to IDLE after the last beat.

Top module: `nor_burst_reader`

## Requirements
- R1: After reset, and in every cycle the block is idle, chip select and output enable are high, latch enable is low, `busy` is low and `rd_valid` is low.
- R2: A request with a beat count of zero is ignored. A request made while `busy` is high is ignored. An ignored request starts no bus activity and does not change the burst in progress.
- R3: The first address of a burst stays on `flash_addr` for latch_setup + latch_hold + cs_delay + oe_delay + first_acc + 3 cycles.
- R4: Each later address of a burst stays on `flash_addr` for seq_acc + 5 cycles and equals the previous address plus one, wrapping modulo 2^AW.
- R5: During a burst, chip select stays high for latch_setup + latch_hold + cs_delay + 2 cycles, counted from the first busy cycle.
- R6: Output enable goes low exactly oe_delay cycles after chip select goes low, and it is never low while chip select is high.
- R7: The flash data bus is sampled in the last cycle of each address window. The sampled word appears on `rd_data` in the following cycle with `rd_valid` high for that one cycle. Exactly beat-count words are delivered, and they come in address order.
- R8: `rd_done` is high only in the cycle of the final `rd_valid`. In that cycle chip select and output enable have both returned high in the same cycle and `busy` is low.
- R9: The timing fields, base address and beat count are captured when a request is accepted. Changing them during the burst has no effect on that burst.
- R10: Latch enable is high for the first latch_setup + 1 cycles of a burst and for the first cycle of every later beat, and it is low at all other times.
- R11: Once chip select and output enable are asserted, each stays low without a gap until the burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Single-cycle burst request |
| req_addr | input | AW | Base word address of the burst |
| req_beats | input | CW | Number of beats; zero is ignored |
| cfg_latch_setup | input | TW | Latch enable duration minus one |
| cfg_latch_hold | input | TW | Address hold after the latch closes, minus one |
| cfg_cs_delay | input | TW | Cycles from the end of latch hold to chip select |
| cfg_oe_delay | input | TW | Cycles from chip select to output enable |
| cfg_first_acc | input | TW | First-beat access time; the sample comes first_acc + 1 cycles after output enable |
| cfg_seq_acc | input | TW | Sequential access time; each later beat lasts seq_acc + 5 cycles |
| flash_data | input | DW | Flash data bus |
| flash_addr | output | AW | Address bus towards the latch and the flash |
| flash_ale | output | 1 | Address latch enable, active high |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_done | output | 1 | Marks the final beat of a burst |
| busy | output | 1 | High while a burst is in progress |

## Verification
The bench builds the block with AW=10, DW=16, CW=4 and TW=3. With these values every timing field can reach both zero and its maximum of 7, so the CSDLY and OEDLY skip paths and the longest windows are all exercised. A base address of 0x3FE makes the address increment wrap through zero. A 4-bit beat count allows a maximum-length burst of 15 beats. The flash model returns a word derived from the address whenever output enable is low, so each captured word shows which address window was sampled.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_LHOLD,
        ST_CSDLY,
        ST_OEDLY,
        ST_FIRST,
        ST_SEQ
    } nbr_state_e;

    // number of timing fields carried by the block
    localparam int NUM_FIELDS = 6;

    // field slots inside the packed timing vector
    localparam int F_SETUP = 0;
    localparam int F_HOLD  = 1;
    localparam int F_CSD   = 2;
    localparam int F_OED   = 3;
    localparam int F_FIRST = 4;
    localparam int F_SEQ   = 5;

    // sequential beat length is seq_acc + SEQ_EXTRA + 1
    localparam int SEQ_EXTRA = 4;

endpackage

// File: rtl/nbr_timing_regs.sv
module nbr_timing_regs #(
    parameter int TW = 4,
    parameter int NF = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NF-1:0][TW-1:0] cfg_in,
    output logic [NF-1:0][TW-1:0] cfg_q
);

    for (genvar g = 0; g < NF; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (capture) begin
                cfg_q[g] <= cfg_in[g];
            end
        end
    end

endmodule

// File: rtl/nbr_phase_ctr.sv
module nbr_phase_ctr #(
    parameter int CTW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CTW-1:0] load_val,
    output logic [CTW-1:0] count,
    output logic           expired
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

endmodule

// File: rtl/nbr_beat_addr.sv
module nbr_beat_addr #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          advance,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] beats,
    output logic [AW-1:0] cur_addr,
    output logic          last_beat
);

    logic [CW-1:0] beats_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            beats_left <= '0;
        end else if (accept) begin
            cur_addr   <= base_addr;
            beats_left <= beats;
        end else if (advance) begin
            cur_addr   <= cur_addr + 1'b1;
            beats_left <= beats_left - 1'b1;
        end
    end

    assign last_beat = (beats_left == CW'(1));

endmodule

// File: rtl/nbr_capture.sv
module nbr_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          final_beat,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] word_out,
    output logic          word_valid,
    output logic          burst_done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            burst_done <= 1'b0;
        end else begin
            word_valid <= sample;
            burst_done <= sample && final_beat;
            if (sample) begin
                word_out <= bus_in;
            end
        end
    end

endmodule

// File: rtl/nor_burst_reader.sv
module nor_burst_reader
    import nbr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_beats,
    input  logic [TW-1:0] cfg_latch_setup,
    input  logic [TW-1:0] cfg_latch_hold,
    input  logic [TW-1:0] cfg_cs_delay,
    input  logic [TW-1:0] cfg_oe_delay,
    input  logic [TW-1:0] cfg_first_acc,
    input  logic [TW-1:0] cfg_seq_acc,
    input  logic [DW-1:0] flash_data,
    output logic [AW-1:0] flash_addr,
    output logic          flash_ale,
    output logic          flash_cs_n,
    output logic          flash_oe_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_done,
    output logic          busy
);

    localparam int CTW = TW + 2;

    nbr_state_e state_q, state_d;

    logic [NUM_FIELDS-1:0][TW-1:0] cfg_in, cfg_q;
    logic           accept;
    logic           sample;
    logic           last_beat;
    logic           ctr_load;
    logic [CTW-1:0] ctr_val;
    logic [CTW-1:0] ctr_count;
    logic           ctr_expired;
    logic [CTW-1:0] seq_load;

    assign cfg_in[F_SETUP] = cfg_latch_setup;
    assign cfg_in[F_HOLD]  = cfg_latch_hold;
    assign cfg_in[F_CSD]   = cfg_cs_delay;
    assign cfg_in[F_OED]   = cfg_oe_delay;
    assign cfg_in[F_FIRST] = cfg_first_acc;
    assign cfg_in[F_SEQ]   = cfg_seq_acc;

    assign seq_load = CTW'(cfg_q[F_SEQ]) + CTW'(SEQ_EXTRA);

    nbr_timing_regs #(
        .TW (TW),
        .NF (NUM_FIELDS)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    nbr_phase_ctr #(
        .CTW (CTW)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .count    (ctr_count),
        .expired  (ctr_expired)
    );

    nbr_beat_addr #(
        .AW (AW),
        .CW (CW)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .advance   (sample),
        .base_addr (req_addr),
        .beats     (req_beats),
        .cur_addr  (flash_addr),
        .last_beat (last_beat)
    );

    nbr_capture #(
        .DW (DW)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .final_beat (last_beat),
        .bus_in     (flash_data),
        .word_out   (rd_data),
        .word_valid (rd_valid),
        .burst_done (rd_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, phase counter loading, accept and sample strobes
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        accept   = 1'b0;
        sample   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start && (req_beats != '0)) begin
                    accept   = 1'b1;
                    state_d  = ST_LATCH;
                    ctr_load = 1'b1;
                    ctr_val  = CTW'(cfg_latch_setup);
                end
            end
            ST_LATCH: begin
                if (ctr_expired) begin
                    state_d  = ST_LHOLD;
                    ctr_load = 1'b1;
                    ctr_val  = CTW'(cfg_q[F_HOLD]);
                end
            end
            ST_LHOLD: begin
                if (ctr_expired) begin
                    ctr_load = 1'b1;
                    if (cfg_q[F_CSD] != '0) begin
                        state_d = ST_CSDLY;
                        ctr_val = CTW'(cfg_q[F_CSD]) - 1'b1;
                    end else if (cfg_q[F_OED] != '0) begin
                        state_d = ST_OEDLY;
                        ctr_val = CTW'(cfg_q[F_OED]) - 1'b1;
                    end else begin
                        state_d = ST_FIRST;
                        ctr_val = CTW'(cfg_q[F_FIRST]);
                    end
                end
            end
            ST_CSDLY: begin
                if (ctr_expired) begin
                    ctr_load = 1'b1;
                    if (cfg_q[F_OED] != '0) begin
                        state_d = ST_OEDLY;
                        ctr_val = CTW'(cfg_q[F_OED]) - 1'b1;
                    end else begin
                        state_d = ST_FIRST;
                        ctr_val = CTW'(cfg_q[F_FIRST]);
                    end
                end
            end
            ST_OEDLY: begin
                if (ctr_expired) begin
                    state_d  = ST_FIRST;
                    ctr_load = 1'b1;
                    ctr_val  = CTW'(cfg_q[F_FIRST]);
                end
            end
            ST_FIRST, ST_SEQ: begin
                if (ctr_expired) begin
                    sample = 1'b1;
                    if (last_beat) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_SEQ;
                        ctr_load = 1'b1;
                        ctr_val  = seq_load;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bus outputs decoded from state
    always_comb begin
        flash_ale  = 1'b0;
        flash_cs_n = 1'b1;
        flash_oe_n = 1'b1;
        busy       = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE, ST_LHOLD, ST_CSDLY: ;
            ST_LATCH: flash_ale = 1'b1;
            ST_OEDLY: flash_cs_n = 1'b0;
            ST_FIRST: begin
                flash_cs_n = 1'b0;
                flash_oe_n = 1'b0;
            end
            ST_SEQ: begin
                flash_cs_n = 1'b0;
                flash_oe_n = 1'b0;
                flash_ale  = (ctr_count == seq_load);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nbr_checker.sv
module nbr_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] flash_addr,
    input logic          flash_ale,
    input logic          flash_cs_n,
    input logic          flash_oe_n,
    input logic          rd_valid,
    input logic          rd_done,
    input logic          busy
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (flash_cs_n && flash_oe_n && !flash_ale)); // R1

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (flash_addr != $past(flash_addr)))
        |-> (flash_addr == AW'($past(flash_addr) + 1'b1))); // R4

    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_oe_n |-> !flash_cs_n); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7

    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_valid && !busy)); // R8

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |-> $rose(flash_oe_n)); // R8

endmodule

bind nor_burst_reader nbr_checker #(
    .AW (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_addr (flash_addr),
    .flash_ale  (flash_ale),
    .flash_cs_n (flash_cs_n),
    .flash_oe_n (flash_oe_n),
    .rd_valid   (rd_valid),
    .rd_done    (rd_done),
    .busy       (busy)
);

// File: tb/tb_nor_burst_reader.sv
module tb_nor_burst_reader;

    localparam int AW = 10;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int TW = 3;
    localparam time CLK_PERIOD = 10ns;

    // vector: {setup, hold, csd, oed, first, seq, addr, beats}
    localparam int NV = 5;
    localparam logic [31:0] VECS [NV] = '{
        {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 10'h010, 4'd1},
        {3'd1, 3'd2, 3'd0, 3'd3, 3'd2, 3'd1, 10'h100, 4'd3},
        {3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 10'h3FE, 4'd4},
        {3'd0, 3'd0, 3'd5, 3'd0, 3'd4, 3'd0, 10'h055, 4'd2},
        {3'd2, 3'd1, 3'd1, 3'd1, 3'd0, 3'd3, 10'h2A0, 4'd15}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_beats = '0;
    logic [TW-1:0] c_setup = '0, c_hold = '0, c_csd = '0;
    logic [TW-1:0] c_oed = '0, c_first = '0, c_seq = '0;
    logic [DW-1:0] flash_data;
    logic [AW-1:0] flash_addr;
    logic          flash_ale, flash_cs_n, flash_oe_n;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_done, busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return (DW'(a) * 16'd41) ^ 16'h5AC3;
    endfunction

    assign flash_data = flash_oe_n ? 16'hFFFF : pat(flash_addr);

    nor_burst_reader #(
        .AW (AW), .DW (DW), .CW (CW), .TW (TW)
    ) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_start       (req_start),
        .req_addr        (req_addr),
        .req_beats       (req_beats),
        .cfg_latch_setup (c_setup),
        .cfg_latch_hold  (c_hold),
        .cfg_cs_delay    (c_csd),
        .cfg_oe_delay    (c_oed),
        .cfg_first_acc   (c_first),
        .cfg_seq_acc     (c_seq),
        .flash_data      (flash_data),
        .flash_addr      (flash_addr),
        .flash_ale       (flash_ale),
        .flash_cs_n      (flash_cs_n),
        .flash_oe_n      (flash_oe_n),
        .rd_data         (rd_data),
        .rd_valid        (rd_valid),
        .rd_done         (rd_done),
        .busy            (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(flash_cs_n && flash_oe_n && !flash_ale && !busy && !rd_valid, req,
              {flash_cs_n, flash_oe_n, flash_ale, busy, rd_valid}, 5'b11000);
    endtask

    task automatic run_burst(input logic [TW-1:0] s, h, c, o, f, q,
                             input logic [AW-1:0] a, input logic [CW-1:0] n,
                             input bit disturb);
        int win[16];
        int nwin = 0, run = 0, ale_cnt = 0, cs_hi = 0, cs_only = 0;
        int gaps = 0, vcnt = 0, dcnt = 0, bad_data = 0, t_end = 0;
        bit cs_seen = 0, oe_seen = 0, done_ok = 1;
        logic [AW-1:0] cur;
        @(negedge clk);
        {c_setup, c_hold, c_csd, c_oed, c_first, c_seq} = {s, h, c, o, f, q};
        req_addr = a; req_beats = n; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (disturb) begin
            {c_setup, c_hold, c_csd, c_oed, c_first, c_seq} = ~{s, h, c, o, f, q};
            req_addr = a ^ 10'h155; req_beats = 4'd7;
        end
        cur = flash_addr;
        for (int t = 0; t < 1000; t++) begin
            if (disturb && t == 3) req_start = 1'b1;
            if (disturb && t == 4) req_start = 1'b0;
            if (rd_valid) begin
                if (rd_data != pat(AW'(a + AW'(vcnt)))) bad_data++;
                vcnt++;
            end
            if (rd_done) begin
                dcnt++;
                if (!(rd_valid && flash_cs_n && flash_oe_n && !busy && vcnt == int'(n)))
                    done_ok = 0;
            end
            if (!busy) begin
                if (nwin < 16) win[nwin] = run;
                nwin++;
                t_end = 1;
                break;
            end
            if (flash_addr == cur) run++;
            else begin
                if (nwin < 16) win[nwin] = run;
                nwin++; cur = flash_addr; run = 1;
            end
            if (flash_ale) ale_cnt++;
            if (flash_cs_n) begin
                cs_hi++;
                if (cs_seen) gaps++;
            end else begin
                cs_seen = 1;
                if (flash_oe_n) begin
                    cs_only++;
                    if (oe_seen) gaps++;
                end else oe_seen = 1;
            end
            @(negedge clk);
        end
        check(t_end == 1, "R8 burst ends", t_end, 1);
        check(nwin == int'(n), "R4 window count", nwin, int'(n));
        check(win[0] == int'(s)+int'(h)+int'(c)+int'(o)+int'(f)+3, "R3 first window",
              win[0], int'(s)+int'(h)+int'(c)+int'(o)+int'(f)+3);
        for (int k = 1; k < int'(n) && k < 16; k++)
            check(win[k] == int'(q)+5, "R4 later window", win[k], int'(q)+5);
        check(cs_hi == int'(s)+int'(h)+int'(c)+2, "R5 select delay", cs_hi,
              int'(s)+int'(h)+int'(c)+2);
        check(cs_only == int'(o), "R6 select to output enable", cs_only, int'(o));
        check(gaps == 0, "R11 no release gap", gaps, 0);
        check(ale_cnt == int'(s)+int'(n), "R10 latch enable cycles", ale_cnt, int'(s)+int'(n));
        check(vcnt == int'(n) && bad_data == 0, "R7 words delivered", vcnt*100+bad_data,
              int'(n)*100);
        check(dcnt == 1 && done_ok, "R8 done with final word", dcnt, 1);
        if (disturb) check(vcnt == int'(n), "R2 R9 busy request ignored", vcnt, int'(n));
        @(negedge clk);
        check_idle("R1 idle after burst");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset release");

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_burst(VECS[i][31:29], VECS[i][28:26], VECS[i][25:23], VECS[i][22:20],
                      VECS[i][19:17], VECS[i][16:14], VECS[i][13:4], VECS[i][3:0], 1'b0);
        end

        // R2: zero-length request ignored
        begin
            int act = 0;
            @(negedge clk);
            req_addr = 10'h1F0; req_beats = '0; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (busy || !flash_cs_n || flash_ale || rd_valid) act++;
                @(negedge clk);
            end
            check(act == 0, "R2 zero beats ignored", act, 0);
        end

        // R2 and R9: request and config changes during a burst
        run_burst(3'd2, 3'd1, 3'd3, 3'd2, 3'd1, 3'd2, 10'h0C0, 4'd5, 1'b1);

        // R1: reset in the middle of a burst
        @(negedge clk);
        {c_setup, c_hold, c_csd, c_oed, c_first, c_seq} = {6{3'd1}};
        req_addr = 10'h033; req_beats = 4'd3; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (8) @(negedge clk);
        check(!flash_cs_n, "R1 burst active before reset", flash_cs_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid burst");
        rst_n = 1'b1;
        @(negedge clk);

        // back-to-back bursts after reset recovery
        run_burst(3'd0, 3'd3, 3'd0, 3'd0, 3'd6, 3'd0, 10'h3FF, 4'd2, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule